// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A command carries a start column, a burst-length code and an ordering select. One clock after the command is taken, the block starts to emit one column address per cycle. Each address comes with a valid flag. A last-beat flag marks the final beat of a fixed-length burst.

Two orderings are supported. Sequential ordering counts the low column bits upward and wraps inside the burst-aligned window. Interleaved ordering XORs the beat index into the low bits of the start column. A full-page length runs sequentially through the whole column space, wraps at the page end, and continues until a terminate input or a new command stops it. A new command accepted at any beat drops the rest of the current burst and starts a fresh burst of full length. Illegal length and ordering combinations are flagged and start nothing.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, out_valid, out_last and out_illegal are all 0.
- R2: A legal command (cmd_valid=1) makes out_valid=1 with out_col equal to cmd_col on the following clock edge.
- R3: With cmd_ilv=0 and a burst length BL of 2, 4 or 8 (cmd_len codes 1, 2, 3), beat i has low log2(BL) bits equal to (start + i) mod BL. The upper column bits keep the start value.
- R4: With cmd_ilv=1 and BL of 2, 4 or 8, beat i has low log2(BL) bits equal to the start low bits XOR i. The upper column bits keep the start value.
- R5: out_last is 1 only on the final beat of a fixed-length burst. On the cycle after that beat, out_valid is 0 unless a new legal command was taken.
- R6: cmd_len=0 (length 1) gives exactly one beat, carrying the start column, with out_last=1.
- R7: cmd_len=7 with cmd_ilv=0 (full page) emits start, start+1, and so on, modulo 512. It wraps from 511 to 0, never raises out_last, and runs until term or a new command.
- R8: term=1 with no command in the same cycle ends the active burst: out_valid is 0 from the next edge.
- R9: A legal command taken during a burst discards the remaining beats. The next output is the new start column, followed by a complete burst of the new length.
- R10: cmd_len=7 with cmd_ilv=1, or a cmd_len of 4, 5 or 6, is illegal. It makes out_illegal=1 for one cycle, starts no burst, and leaves any burst in progress running unchanged.
- R11: Legal commands are accepted on consecutive cycles, and each one produces its own first beat one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Burst command strobe |
| cmd_col | input | 9 | Start column of the command |
| cmd_len | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| cmd_ilv | input | 1 | 1 selects interleaved order, 0 sequential |
| term | input | 1 | Stops the active burst |
| out_valid | output | 1 | A column address is present this cycle |
| out_col | output | 9 | Column address of the current beat |
| out_last | output | 1 | Final beat of a fixed-length burst |
| out_illegal | output | 1 | The previous cycle's command was rejected |

## Verification
The embedded assertions check the following on every cycle:
- a legal command starts at its own column one cycle later;
- the last flag only appears with a valid beat;
- the output goes idle after a last beat or a terminate;
- a running burst keeps going while nothing stops it;
- length-1 bursts are single beats;
- illegal requests raise the flag and start nothing.

The actual address orderings can only be shown by the bench's directed scenarios. These cover the modulo and XOR patterns with non-zero upper bits, the full-page wrap across 511, interruption mid-burst, and back-to-back commands.

// File: rtl/bcs_pkg.sv
// Shared length codes for the burst column sequencer.
// Assumes a 3-bit length code; codes 4..6 are reserved.
package bcs_pkg;
    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;
endpackage

// File: rtl/bcs_cmd_check.sv
// Decides whether a command's length/order pair may start a burst.
// Assumes: full page only with sequential order; reserved codes are rejected.
module bcs_cmd_check
    import bcs_pkg::*;
(
    input  logic [2:0] len,
    input  logic       ilv,
    output logic       legal
);
    // Legality decode of length code and ordering select.
    always_comb begin
        unique case (len)
            LEN_1, LEN_2, LEN_4, LEN_8: legal = 1'b1;
            LEN_PAGE:                   legal = ~ilv;
            default:                    legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcs_addr_gen.sv
// Forms the column for a beat from the start column, the beat index and the
// window mask. Sequential adds within the window, interleave XORs within it.
// Assumes mask is a contiguous low-order run of ones.
module bcs_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_sum;
    logic [COL_W-1:0] low_xor;

    // Combine fixed upper bits with the wrapped low bits.
    always_comb begin
        low_sum = start + beat;
        low_xor = start ^ beat;
        col     = (start & ~mask) | ((ilv ? low_xor : low_sum) & mask);
    end
endmodule

// File: rtl/bcs_beat_ctrl.sv
// Holds the burst in progress (start, length, order, beat index) and exposes
// the state for the next cycle so the top can register its outputs from it.
// Assumes cmd_take is only raised for legal commands; cmd_take beats term.
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_take,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       cmd_len,
    input  logic             cmd_ilv,
    input  logic             term,
    output logic             n_active,
    output logic [COL_W-1:0] n_start,
    output logic [COL_W-1:0] n_beat,
    output logic [COL_W-1:0] n_mask,
    output logic             n_ilv,
    output logic             n_last
);
    logic             active_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] beat_q;
    logic [2:0]       len_q;
    logic             ilv_q;
    logic [2:0]       n_len;
    logic             last_now;

    function automatic logic [COL_W-1:0] mask_of(input logic [2:0] code);
        logic [COL_W-1:0] m;
        unique case (code)
            LEN_1:   m = '0;
            LEN_2:   m = COL_W'(1);
            LEN_4:   m = COL_W'(3);
            LEN_8:   m = COL_W'(7);
            default: m = '1;
        endcase
        return m;
    endfunction

    // Whether the beat now on the outputs is the final one.
    always_comb begin
        last_now = active_q && (len_q != LEN_PAGE) && (beat_q == mask_of(len_q));
    end

    // Next-state selection: restart, advance, or go idle.
    always_comb begin
        n_start = start_q;
        n_len   = len_q;
        n_ilv   = ilv_q;
        n_beat  = beat_q;
        if (cmd_take) begin
            n_active = 1'b1;
            n_start  = cmd_col;
            n_len    = cmd_len;
            n_ilv    = cmd_ilv;
            n_beat   = '0;
        end else if (active_q && !term && !last_now) begin
            n_active = 1'b1;
            n_beat   = beat_q + COL_W'(1);
        end else begin
            n_active = 1'b0;
        end
        n_mask = mask_of(n_len);
        n_last = n_active && (n_len != LEN_PAGE) && (n_beat == n_mask);
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            start_q  <= '0;
            beat_q   <= '0;
            len_q    <= LEN_1;
            ilv_q    <= 1'b0;
        end else begin
            active_q <= n_active;
            start_q  <= n_start;
            beat_q   <= n_beat;
            len_q    <= n_len;
            ilv_q    <= n_ilv;
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Burst column address sequencer top. Registers one column per clock with
// valid, last-beat and illegal-command flags.
// Assumes a legal command always wins over term in the same cycle.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       cmd_len,
    input  logic             cmd_ilv,
    input  logic             term,
    output logic             out_valid,
    output logic [COL_W-1:0] out_col,
    output logic             out_last,
    output logic             out_illegal
);
    logic             legal;
    logic             cmd_take;
    logic             n_active;
    logic [COL_W-1:0] n_start;
    logic [COL_W-1:0] n_beat;
    logic [COL_W-1:0] n_mask;
    logic             n_ilv;
    logic             n_last;
    logic [COL_W-1:0] n_col;

    bcs_cmd_check u_check (
        .len   (cmd_len),
        .ilv   (cmd_ilv),
        .legal (legal)
    );

    // Only legal commands reach the burst controller.
    always_comb cmd_take = cmd_valid && legal;

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_take (cmd_take),
        .cmd_col  (cmd_col),
        .cmd_len  (cmd_len),
        .cmd_ilv  (cmd_ilv),
        .term     (term),
        .n_active (n_active),
        .n_start  (n_start),
        .n_beat   (n_beat),
        .n_mask   (n_mask),
        .n_ilv    (n_ilv),
        .n_last   (n_last)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .start (n_start),
        .beat  (n_beat),
        .mask  (n_mask),
        .ilv   (n_ilv),
        .col   (n_col)
    );

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_col     <= '0;
            out_last    <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= n_active;
            out_col     <= n_col;
            out_last    <= n_last;
            out_illegal <= cmd_valid && !legal;
        end
    end

    // R2: a legal command shows its own start column next cycle.
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_len <= LEN_8 || (cmd_len == LEN_PAGE && !cmd_ilv)))
        |=> (out_valid && out_col == $past(cmd_col)));

    // R5: last only accompanies a valid beat.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R5: idle after the last beat unless a command restarts.
    p_idle_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && !cmd_valid) |=> !out_valid);

    // R6: a length-1 command is a single, last beat.
    p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_len == LEN_1) |=> out_last);

    // R8: term without a command stops output.
    p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !cmd_valid) |=> !out_valid);

    // R7: an unfinished burst keeps running while nothing stops it.
    p_burst_continues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && !cmd_valid && !term) |=> out_valid);

    // R10: full-page interleave is flagged and starts nothing from idle.
    p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_len == LEN_PAGE && cmd_ilv) |=> out_illegal);

    p_illegal_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_len == LEN_PAGE && cmd_ilv && !out_valid) |=> !out_valid);
endmodule

// File: tb/burst_col_seq_tb_top.sv
// Directed bench for burst_col_seq: one task per scenario.
module burst_col_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [8:0] cmd_col;
    logic [2:0] cmd_len;
    logic       cmd_ilv;
    logic       term;
    logic       out_valid;
    logic [8:0] out_col;
    logic       out_last;
    logic       out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    burst_col_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_col     (cmd_col),
        .cmd_len     (cmd_len),
        .cmd_ilv     (cmd_ilv),
        .term        (term),
        .out_valid   (out_valid),
        .out_col     (out_col),
        .out_last    (out_last),
        .out_illegal (out_illegal)
    );

    // Expected column of beat i, computed from the requirement arithmetic.
    function automatic int exp_col(int start, int bl, bit ilv, int i);
        int base = start - (start % bl);
        int low  = start % bl;
        if (ilv) return base + (low ^ i);
        return base + ((low + i) % bl);
    endfunction

    task automatic chk(string req, logic v, int col, logic last, logic ill);
        n_checks++;
        if (out_valid !== v || (v && out_col !== 9'(col)) ||
            out_last !== last || out_illegal !== ill) begin
            n_fails++;
            $display("FAIL %s: got v=%0b col=%0d last=%0b ill=%0b, exp v=%0b col=%0d last=%0b ill=%0b",
                     req, out_valid, out_col, out_last, out_illegal, v, col, last, ill);
        end
    endtask

    // Drive a command for one cycle; returns at the negedge after it is taken.
    task automatic issue(int col, int len, bit ilv);
        cmd_valid = 1'b1;
        cmd_col   = 9'(col);
        cmd_len   = 3'(len);
        cmd_ilv   = ilv;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Run a whole fixed-length burst and check each beat plus the idle after.
    task automatic run_fixed(string req, int start, int len, bit ilv);
        int bl = 1 << len;
        issue(start, len, ilv);
        for (int i = 0; i < bl; i++) begin
            chk(req, 1'b1, exp_col(start, bl, ilv, i), i == bl - 1, 1'b0);
            @(negedge clk);
        end
        chk("R5 idle after last", 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_seq();
        run_fixed("R3 seq BL4 start 2", 2, 2, 1'b0);
        run_fixed("R3 seq BL4 upper bits", 9'h1F6, 2, 1'b0);
        run_fixed("R3 seq BL8 start 13", 13, 3, 1'b0);
        run_fixed("R3 seq BL2 start 1", 1, 1, 1'b0);
    endtask

    task automatic t_ilv();
        run_fixed("R4 ilv BL8 start 5", 5, 3, 1'b1);
        run_fixed("R4 ilv BL4 start 0x1A3", 9'h1A3, 2, 1'b1);
    endtask

    task automatic t_bl1();
        run_fixed("R6 BL1 start 0x155", 9'h155, 0, 1'b1);
    endtask

    task automatic t_page();
        issue(510, 7, 1'b0);
        for (int i = 0; i < 6; i++) begin
            chk("R7 full page wrap", 1'b1, (510 + i) % 512, 1'b0, 1'b0);
            @(negedge clk);
        end
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R8 term ends page", 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_term_fixed();
        issue(16, 3, 1'b0);
        chk("R8 beat0", 1'b1, 16, 1'b0, 1'b0);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R8 term ends BL8", 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_interrupt();
        issue(0, 3, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R9 before interrupt", 1'b1, i, 1'b0, 1'b0);
            if (i < 2) @(negedge clk);
        end
        run_fixed("R9 restart ilv BL4 at 0x13", 9'h13, 2, 1'b1);
    endtask

    task automatic t_illegal();
        issue(40, 7, 1'b1);
        chk("R10 page+ilv from idle", 1'b0, 0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10 flag is one cycle", 1'b0, 0, 1'b0, 1'b0);
        issue(40, 5, 1'b0);
        chk("R10 reserved code", 1'b0, 0, 1'b0, 1'b1);
        issue(8, 2, 1'b0);
        chk("R10 burst beat0", 1'b1, 8, 1'b0, 1'b0);
        issue(100, 7, 1'b1);
        chk("R10 burst unaffected", 1'b1, 9, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10 burst beat2", 1'b1, 10, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 burst beat3", 1'b1, 11, 1'b1, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        cmd_valid = 1'b1; cmd_len = 3'd1; cmd_ilv = 1'b0; cmd_col = 9'd4;
        @(negedge clk);
        chk("R11 first", 1'b1, 4, 1'b0, 1'b0);
        cmd_col = 9'd7;
        @(negedge clk);
        chk("R11 second", 1'b1, 7, 1'b0, 1'b0);
        cmd_col = 9'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11 third", 1'b1, 1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 third ends", 1'b1, 0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R11 idle", 1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_col = '0; cmd_len = '0;
        cmd_ilv = 1'b0; term = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_ilv();
        t_bl1();
        t_page();
        t_term_fixed();
        t_interrupt();
        t_illegal();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule